// File: doc/BRIEF.md
# Half-Duplex SPI Master Controller

This block is a serial peripheral master that moves a counted run of 8-bit words in one direction per command. A host programs it over a small register bus: a configuration word sets the serial clock ratio, the clock polarity and phase and the word-length code, and a command word sets the byte count, the direction, the target select and the chip-select hold behaviour. Transmit bytes are written to a data port that feeds a small transmit FIFO. Received bytes collect in a receive FIFO and are read back through the same data port. Programmed I/O or an external DMA engine can drive the port.

The serial clock runs at the block clock divided by a fixed prescale and then by the programmed ratio. A prescale parameter below 2 counts as 2. Chip select goes active on the selected line at least half a serial period before the first clock edge. It is released half a period after the last edge, unless the command asked to keep it held so that the next command continues the same frame. Misuse of the bus sets sticky error flags, which are cleared by writing ones. The serial side never overruns or underruns: when the transmit FIFO is empty, or the receive FIFO is full, at a byte boundary, the shifter waits with the clock idle. The host uses the FIFO flags in the status word as its back-pressure signals.

Register map (word address on `bus_addr`): 0 command, 1 configuration, 2 data, 3 status.

Top module: `hd_spi_master`

## Requirements
- R1: After reset every chip-select line is high and `sclk` is 0. Status reads 0x0000000A (bit 0 busy = 0, bit 1 RX empty = 1, bit 2 TX full = 0, bit 3 TX empty = 1). Configuration reads 0x00004000 (word-length code 4 in bits [14:12], all other fields and flags 0).
- R2: With the default prescale of 2, each serial clock phase lasts (rate+1) block clocks, where rate is configuration bits [7:0]. One full `sclk` period is therefore 2*(rate+1) clocks.
- R3: Configuration bit 8 (polarity) sets the idle level of `sclk`. Bit 9 (phase) set to 0 samples on the leading edge and set to 1 samples on the trailing edge. Bytes go out and come in MSB first.
- R4: A transmit command (command bit 16 = 0) shifts out, in FIFO order, as many bytes as command bits [15:0] give, with exactly 16 `sclk` edges per byte.
- R5: A receive command (command bit 16 = 1) holds `mosi` high, captures `miso` into the RX FIFO, and returns each byte in bits [7:0] of a data read.
- R6: Writing the command word with bit 18 (run) set starts a command, and bit 18 or status bit 0 reads 1 until it ends. When the count is 0 or bit 17 (data enable) is clear, the command ends with no `sclk` edge.
- R7: Command bits [22:21] give the select number n, and only `cs_n[n]` goes low. `sclk` leaves its idle level only while a chip select is active.
- R8: Command bit 19 (hold) with bit 20 (release) clear leaves chip select low after the count ends. When bit 20 is set, or bit 19 is clear, chip select goes high half a period after the last edge.
- R9: A data write while the TX FIFO is full is dropped and sets configuration bit 31.
- R10: A data read while the RX FIFO is empty returns 0 and sets configuration bit 30.
- R11: A command write while busy is ignored. If it has run set, it sets configuration bit 27, and the running command goes on unchanged.
- R12: A run request while the word-length code is not 4 does not start a command and sets configuration bit 26.
- R13: Error flags stay set until a configuration write has a 1 in that flag's position. Only bits within mask 0xCCCC0000 clear, and flags written 0 stay set.
- R14: A transmit command whose next byte has not been written waits at the byte boundary with `sclk` idle and busy set, and it resumes when the byte arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX FIFO at data address) |
| bus_addr | input | 2 | Word address: 0 command, 1 configuration, 2 data, 3 status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects, one per select number |

## Verification
The assertions assume that the host gates its own accesses as the status word tells it to. FIFO pushes and pops happen only when the FIFO can take them, because the block turns any other access into an error flag. The serial timing checks assume that polarity, phase and rate change only while no command is running. The bench writes configuration only between commands, reads status until busy clears before it issues the next command, and drives `miso` from a slave model that changes its bit only after the master's sampling edge.

// File: rtl/hd_spi_pkg.sv
`timescale 1ns/1ps
package hd_spi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_HOLD} eng_state_e;

  localparam logic [1:0] A_CMD  = 2'd0;
  localparam logic [1:0] A_CFG  = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  // command word fields
  localparam int C_DIR  = 16;
  localparam int C_XFER = 17;
  localparam int C_RUN  = 18;
  localparam int C_HOLD = 19;
  localparam int C_REL  = 20;
  localparam int C_SEL  = 21;

  // configuration word fields
  localparam int F_CPOL = 8;
  localparam int F_CPHA = 9;
  localparam int F_WLEN = 12;
  localparam logic [2:0] WLEN_BYTE = 3'd4;

  // sticky error positions, all inside the write-one-to-clear mask
  localparam int E_WLEN = 26;
  localparam int E_BUSY = 27;
  localparam int E_UDF  = 30;
  localparam int E_OVF  = 31;
  localparam logic [31:0] ERR_MASK = 32'hCCCC_0000;
endpackage

// File: rtl/hd_spi_fifo.sv
`timescale 1ns/1ps
module hd_spi_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, rp_q;
  logic [AW:0]      cnt_q;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end

  // the owner must gate accesses with the flags
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/hd_spi_engine.sv
`timescale 1ns/1ps
module hd_spi_engine
  import hd_spi_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              dir_rx,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [RATE_W-1:0] rate,
  input  logic              keep_cs,
  input  logic              tx_valid,
  input  logic [7:0]        tx_byte,
  input  logic              rx_ready,
  input  logic              miso,
  output logic              tx_pop,
  output logic              rx_push,
  output logic [7:0]        rx_byte,
  output logic              busy,
  output logic              cs_act,
  output logic              sclk,
  output logic              mosi
);
  localparam int HALF_MUL = (PRESCALE < 2) ? 1 : PRESCALE / 2;
  localparam int DIV_W    = RATE_W + $clog2(HALF_MUL + 1) + 2;

  eng_state_e        st_q;
  logic [DIV_W-1:0]  div_q, half_lim_q;
  logic [3:0]        edge_q;
  logic [CNT_W-1:0]  left_q;
  logic [7:0]        txsr_q, rxsr_q;
  logic              phase_q, cpol_q, cpha_q, rx_q, keep_q, cs_q;
  logic              tick, samp, launch, load_ok, last_edge;

  assign tick      = (div_q == half_lim_q - DIV_W'(1));
  assign samp      = (edge_q[0] == cpha_q);
  assign launch    = !samp && !(cpha_q && edge_q == 4'd0);
  assign last_edge = (edge_q == 4'd15);
  assign load_ok   = rx_q ? rx_ready : tx_valid;
  assign tx_pop    = (st_q == ST_LOAD) && !rx_q && tx_valid;
  assign rx_push   = (st_q == ST_SHIFT) && tick && last_edge && rx_q;
  assign rx_byte   = cpha_q ? {rxsr_q[6:0], miso} : rxsr_q;
  assign busy      = (st_q != ST_IDLE);
  assign cs_act    = cs_q;
  assign sclk      = phase_q ^ cpol_q;
  assign mosi      = txsr_q[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      div_q      <= '0;
      half_lim_q <= DIV_W'(1);
      edge_q     <= '0;
      left_q     <= '0;
      txsr_q     <= 8'hFF;
      rxsr_q     <= '0;
      phase_q    <= 1'b0;
      cpol_q     <= 1'b0;
      cpha_q     <= 1'b0;
      rx_q       <= 1'b0;
      keep_q     <= 1'b0;
      cs_q       <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          cpol_q <= cpol;
          if (start) begin
            cpha_q     <= cpha;
            rx_q       <= dir_rx;
            keep_q     <= keep_cs;
            left_q     <= cnt;
            half_lim_q <= DIV_W'(HALF_MUL * (int'(rate) + 1));
            div_q      <= '0;
            cs_q       <= 1'b1;
            st_q       <= (cnt == '0) ? ST_HOLD : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (load_ok) begin
            txsr_q <= rx_q ? 8'hFF : tx_byte;
            edge_q <= '0;
            div_q  <= '0;
            st_q   <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            div_q   <= '0;
            phase_q <= ~phase_q;
            edge_q  <= edge_q + 4'd1;
            if (samp)   rxsr_q <= {rxsr_q[6:0], miso};
            if (launch) txsr_q <= {txsr_q[6:0], 1'b1};
            if (last_edge) begin
              left_q <= left_q - 1'b1;
              st_q   <= (left_q == CNT_W'(1)) ? ST_HOLD : ST_LOAD;
            end
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
        default: begin
          if (tick) begin
            cs_q   <= keep_q;
            div_q  <= '0;
            txsr_q <= 8'hFF;
            st_q   <= ST_IDLE;
          end else begin
            div_q <= div_q + 1'b1;
          end
        end
      endcase
    end
  end

  assert_half_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(phase_q) |-> ($past(st_q) == ST_SHIFT) && (div_q == '0));
  assert_sclk_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_SHIFT) |-> (sclk == cpol_q));
  assert_clock_needs_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != cpol_q) |-> cs_q);
endmodule

// File: rtl/hd_spi_master.sv
`timescale 1ns/1ps
module hd_spi_master
  import hd_spi_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int RATE_W     = 8,
  parameter int PRESCALE   = 2,
  parameter int FIFO_DEPTH = 4,
  parameter int SEL_W      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [1:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  output logic                    sclk,
  output logic                    mosi,
  input  logic                    miso,
  output logic [(1<<SEL_W)-1:0]   cs_n
);
  localparam int NUM_CS = 1 << SEL_W;

  logic [CNT_W-1:0]  cmd_cnt_q;
  logic              cmd_rx_q, cmd_xfer_q, cmd_hold_q, cmd_rel_q;
  logic [SEL_W-1:0]  cmd_sel_q;
  logic [RATE_W-1:0] cfg_rate_q;
  logic              cfg_cpol_q, cfg_cpha_q;
  logic [2:0]        cfg_wlen_q;
  logic [3:0]        err_q, err_set, err_clr;

  logic cmd_wr, cfg_wr, dat_wr, dat_rd, busy, start, cs_act;
  logic tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
  logic [7:0] tx_dout, rx_byte, rx_dout;
  logic [31:0] cmd_rd, cfg_rd;

  assign cmd_wr = bus_wr && (bus_addr == A_CMD);
  assign cfg_wr = bus_wr && (bus_addr == A_CFG);
  assign dat_wr = bus_wr && (bus_addr == A_DATA);
  assign dat_rd = bus_rd && (bus_addr == A_DATA);
  assign start  = cmd_wr && !busy && bus_wdata[C_RUN] && (cfg_wlen_q == WLEN_BYTE);

  // error order: {overflow, underflow, busy write, word length}
  assign err_set = {dat_wr && tx_full, dat_rd && rx_empty,
                    cmd_wr && busy && bus_wdata[C_RUN],
                    cmd_wr && !busy && bus_wdata[C_RUN] && (cfg_wlen_q != WLEN_BYTE)};
  assign err_clr = cfg_wr ? {bus_wdata[E_OVF], bus_wdata[E_UDF],
                             bus_wdata[E_BUSY], bus_wdata[E_WLEN]} : 4'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_cnt_q  <= '0;
      cmd_rx_q   <= 1'b0;
      cmd_xfer_q <= 1'b0;
      cmd_hold_q <= 1'b0;
      cmd_rel_q  <= 1'b0;
      cmd_sel_q  <= '0;
      cfg_rate_q <= '0;
      cfg_cpol_q <= 1'b0;
      cfg_cpha_q <= 1'b0;
      cfg_wlen_q <= WLEN_BYTE;
      err_q      <= '0;
    end else begin
      if (cmd_wr && !busy) begin
        cmd_cnt_q  <= bus_wdata[CNT_W-1:0];
        cmd_rx_q   <= bus_wdata[C_DIR];
        cmd_xfer_q <= bus_wdata[C_XFER];
        cmd_hold_q <= bus_wdata[C_HOLD];
        cmd_rel_q  <= bus_wdata[C_REL];
        cmd_sel_q  <= bus_wdata[C_SEL +: SEL_W];
      end
      if (cfg_wr) begin
        cfg_rate_q <= bus_wdata[RATE_W-1:0];
        cfg_cpol_q <= bus_wdata[F_CPOL];
        cfg_cpha_q <= bus_wdata[F_CPHA];
        cfg_wlen_q <= bus_wdata[F_WLEN +: 3];
      end
      err_q <= (err_q & ~err_clr) | err_set;
    end
  end

  hd_spi_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk, .rst_n, .push(dat_wr && !tx_full), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout), .empty(tx_empty), .full(tx_full));

  hd_spi_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk, .rst_n, .push(rx_push), .din(rx_byte),
    .pop(dat_rd && !rx_empty), .dout(rx_dout), .empty(rx_empty), .full(rx_full));

  hd_spi_engine #(.CNT_W(CNT_W), .RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_eng (
    .clk, .rst_n, .start,
    .cnt(bus_wdata[C_XFER] ? bus_wdata[CNT_W-1:0] : '0),
    .dir_rx(bus_wdata[C_DIR]), .cpol(cfg_cpol_q), .cpha(cfg_cpha_q),
    .rate(cfg_rate_q), .keep_cs(bus_wdata[C_HOLD] && !bus_wdata[C_REL]),
    .tx_valid(!tx_empty), .tx_byte(tx_dout), .rx_ready(!rx_full), .miso,
    .tx_pop, .rx_push, .rx_byte, .busy, .cs_act, .sclk, .mosi);

  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n[g] = !(cs_act && (cmd_sel_q == SEL_W'(g)));
  end

  always_comb begin
    cmd_rd = '0;
    cmd_rd[CNT_W-1:0]       = cmd_cnt_q;
    cmd_rd[C_DIR]           = cmd_rx_q;
    cmd_rd[C_XFER]          = cmd_xfer_q;
    cmd_rd[C_RUN]           = busy;
    cmd_rd[C_HOLD]          = cmd_hold_q;
    cmd_rd[C_REL]           = cmd_rel_q;
    cmd_rd[C_SEL +: SEL_W]  = cmd_sel_q;
    cfg_rd = '0;
    cfg_rd[RATE_W-1:0]      = cfg_rate_q;
    cfg_rd[F_CPOL]          = cfg_cpol_q;
    cfg_rd[F_CPHA]          = cfg_cpha_q;
    cfg_rd[F_WLEN +: 3]     = cfg_wlen_q;
    {cfg_rd[E_OVF], cfg_rd[E_UDF], cfg_rd[E_BUSY], cfg_rd[E_WLEN]} = err_q;
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_rd;
      A_CFG:   bus_rdata = cfg_rd;
      A_DATA:  bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_dout};
      default: bus_rdata = {28'h0, tx_empty, tx_full, rx_empty, busy};
    endcase
  end

  assert_start_needs_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_single_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  assert_err_sticky_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_q) & ~err_q)) |-> $past(cfg_wr));
endmodule

// File: tb/hd_spi_master_bench.sv
`timescale 1ns/1ps
module hd_spi_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso;
  logic [3:0] cs_n;

  always #10 clk = ~clk;

  hd_spi_master u_hd_spi_master (
    .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
    .sclk, .mosi, .miso, .cs_n);

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // slave model
  bit b_cpol = 0, b_cpha = 0;
  int s_bits = 0, edge_cnt = 0, rise_n = 0;
  time rise_t [0:1];
  logic [7:0] s_sh = '0;
  logic [7:0] s_cap [0:7];
  logic [7:0] s_mb [0:7];
  logic [3:0] s_csn_seen = 4'hF;

  assign miso = s_mb[(s_bits / 8) % 8][7 - (s_bits % 8)];

  always @(posedge sclk or negedge sclk) begin
    if (!(&cs_n)) begin
      edge_cnt++;
      s_csn_seen = cs_n;
      if (sclk && rise_n < 2) begin rise_t[rise_n] = $time; rise_n++; end
      if (sclk == (b_cpol == b_cpha)) begin
        s_sh = {s_sh[6:0], mosi};
        s_bits++;
        if (s_bits % 8 == 0) s_cap[(s_bits / 8 - 1) % 8] = s_sh;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd3, s);
      if (!s[0]) break;
    end
  endtask

  task automatic slave_reset();
    s_bits = 0; edge_cnt = 0; rise_n = 0; s_csn_seen = 4'hF;
  endtask

  function automatic logic [31:0] cmdw(input int cnt, input bit rx, input bit xf,
                                       input bit lk, input bit rl, input int sel);
    return (32'(cnt) & 32'hFFFF) | (32'(rx) << 16) | (32'(xf) << 17) | (32'h1 << 18)
         | (32'(lk) << 19) | (32'(rl) << 20) | ((32'(sel) & 32'h3) << 21);
  endfunction

  function automatic logic [31:0] cfgw(input bit pol, input bit pha, input int rate,
                                       input int wlen, input logic [31:0] clr);
    return (32'(rate) & 32'hFF) | (32'(pol) << 8) | (32'(pha) << 9)
         | ((32'(wlen) & 32'h7) << 12) | clr;
  endfunction

  task automatic set_mode(input bit pol, input bit pha, input int rate);
    b_cpol = pol; b_cpha = pha;
    wr(2'd1, cfgw(pol, pha, rate, 4, 32'h0));
  endtask

  // {cpol, cpha, rate[7:0], byte0, byte1}
  localparam logic [25:0] VEC [0:5] = '{
    {1'b0, 1'b0, 8'd0, 8'hA5, 8'h3C},
    {1'b0, 1'b1, 8'd1, 8'h81, 8'h7E},
    {1'b1, 1'b0, 8'd2, 8'hC3, 8'h5A},
    {1'b1, 1'b1, 8'd0, 8'h0F, 8'hF0},
    {1'b0, 1'b0, 8'd3, 8'hFF, 8'h00},
    {1'b1, 1'b1, 8'd1, 8'h96, 8'h69}
  };

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'h1, 32'h0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    for (int i = 0; i < 8; i++) begin s_mb[i] = 8'h00; s_cap[i] = 8'h00; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_eq("R1 cs_n", {28'h0, cs_n}, 32'hF);
    chk_eq("R1 sclk", {31'h0, sclk}, 32'h0);
    rd(2'd3, r); chk_eq("R1 status", r, 32'h0000000A);
    rd(2'd1, r); chk_eq("R1 config", r, 32'h00004000);

    // table walk: transmit then receive in each mode (R3 R4 R5)
    for (int v = 0; v < 6; v++) begin
      bit pol, pha; int rate; logic [7:0] b0, b1;
      {pol, pha} = VEC[v][25:24]; rate = int'(VEC[v][23:16]);
      b0 = VEC[v][15:8]; b1 = VEC[v][7:0];
      set_mode(pol, pha, rate);
      repeat (3) @(negedge clk);
      chk_eq("R3 idle level", {31'h0, sclk}, {31'h0, pol});
      slave_reset();
      wr(2'd2, {24'h0, b0}); wr(2'd2, {24'h0, b1});
      wr(2'd0, cmdw(2, 0, 1, 0, 0, 0));
      wait_idle();
      chk_eq("R4 first byte", {24'h0, s_cap[0]}, {24'h0, b0});
      chk_eq("R4 second byte", {24'h0, s_cap[1]}, {24'h0, b1});
      chk_eq("R4 edge count", 32'(edge_cnt), 32'd32);
      slave_reset();
      s_mb[0] = ~b0; s_mb[1] = b1 ^ 8'h55;
      wr(2'd0, cmdw(2, 1, 1, 0, 0, 0));
      wait_idle();
      chk_eq("R5 mosi high", {24'h0, s_cap[0]}, 32'hFF);
      rd(2'd2, r); chk_eq("R5 rx byte0", r, {24'h0, ~b0});
      rd(2'd2, r); chk_eq("R5 rx byte1", r, {24'h0, b1 ^ 8'h55});
      chk_eq("R3 idle after", {31'h0, sclk}, {31'h0, pol});
    end

    // R2 clock period at rate 3
    set_mode(0, 0, 3);
    slave_reset();
    wr(2'd2, 32'h5C);
    wr(2'd0, cmdw(1, 0, 1, 0, 0, 0));
    wait_idle();
    chk_eq("R2 period ns", 32'(rise_t[1] - rise_t[0]), 32'd160);

    // R7 select lines
    set_mode(0, 0, 0);
    slave_reset();
    wr(2'd2, 32'h11);
    wr(2'd0, cmdw(1, 0, 1, 0, 0, 2));
    wait_idle();
    chk_eq("R7 select 2", {28'h0, s_csn_seen}, 32'hB);
    slave_reset();
    wr(2'd2, 32'h22);
    wr(2'd0, cmdw(1, 0, 1, 0, 0, 3));
    wait_idle();
    chk_eq("R7 select 3", {28'h0, s_csn_seen}, 32'h7);
    chk_eq("R7 released", {28'h0, cs_n}, 32'hF);

    // R8 hold and release
    slave_reset();
    wr(2'd2, 32'h33);
    wr(2'd0, cmdw(1, 0, 1, 1, 0, 1));
    wait_idle();
    chk_eq("R8 held", {28'h0, cs_n}, 32'hD);
    wr(2'd2, 32'h44);
    wr(2'd0, cmdw(1, 0, 1, 1, 1, 1));
    wait_idle();
    chk_eq("R8 release", {28'h0, cs_n}, 32'hF);
    chk_eq("R8 frame bytes", {16'h0, s_cap[0], s_cap[1]}, 32'h3344);

    // R6 zero count and disabled data transfer
    set_mode(0, 0, 3);
    slave_reset();
    wr(2'd0, cmdw(5, 0, 0, 0, 0, 0));
    rd(2'd0, r); chk_eq("R6 run reads busy", {31'h0, r[18]}, 32'h1);
    wait_idle();
    rd(2'd0, r); chk_eq("R6 run clears", {31'h0, r[18]}, 32'h0);
    wr(2'd0, cmdw(0, 0, 1, 0, 0, 0));
    wait_idle();
    chk_eq("R6 no edges", 32'(edge_cnt), 32'd0);

    // R14 stall on empty transmit FIFO
    set_mode(0, 0, 0);
    slave_reset();
    wr(2'd2, 32'hE7);
    wr(2'd0, cmdw(2, 0, 1, 0, 0, 0));
    repeat (100) @(negedge clk);
    rd(2'd3, r); chk_eq("R14 still busy", {31'h0, r[0]}, 32'h1);
    chk_eq("R14 stalled edges", 32'(edge_cnt), 32'd16);
    chk_eq("R14 clock idle", {31'h0, sclk}, 32'h0);
    wr(2'd2, 32'h18);
    wait_idle();
    chk_eq("R14 resumed", {16'h0, s_cap[0], s_cap[1]}, 32'hE718);

    // R9 overflow drop and R13 clearing
    for (int i = 0; i < 5; i++) wr(2'd2, 32'(8'h60 + i));
    rd(2'd3, r); chk_eq("R9 tx full", {31'h0, r[2]}, 32'h1);
    rd(2'd1, r); chk_eq("R9 overflow flag", {31'h0, r[31]}, 32'h1);
    wr(2'd1, cfgw(0, 0, 0, 4, 32'h8000_0000));
    rd(2'd1, r); chk_eq("R13 cleared", r, 32'h00004000);
    slave_reset();
    wr(2'd0, cmdw(4, 0, 1, 0, 0, 0));
    wait_idle();
    chk_eq("R9 kept bytes", {s_cap[0], s_cap[1], s_cap[2], s_cap[3]}, 32'h60616263);
    rd(2'd3, r); chk_eq("R9 fifo drained", {31'h0, r[3]}, 32'h1);

    // R10 underflow, R13 selective clear
    rd(2'd2, r); chk_eq("R10 empty read", r, 32'h0);
    rd(2'd1, r); chk_eq("R10 underflow flag", {31'h0, r[30]}, 32'h1);
    wr(2'd1, cfgw(0, 0, 0, 4, 32'h0800_0000));
    rd(2'd1, r); chk_eq("R13 other flag kept", {31'h0, r[30]}, 32'h1);
    wr(2'd1, cfgw(0, 0, 0, 4, 32'h4000_0000));
    rd(2'd1, r); chk_eq("R13 flag cleared", {31'h0, r[30]}, 32'h0);

    // R11 command write while busy
    set_mode(0, 0, 10);
    slave_reset();
    s_mb[0] = 8'h9A; s_mb[1] = 8'hBC;
    wr(2'd0, cmdw(2, 1, 1, 0, 0, 0));
    wr(2'd0, cmdw(7, 0, 1, 0, 0, 3));
    rd(2'd1, r); chk_eq("R11 busy flag", {31'h0, r[27]}, 32'h1);
    wait_idle();
    chk_eq("R11 edges unchanged", 32'(edge_cnt), 32'd32);
    rd(2'd2, r); chk_eq("R11 rx0", r, 32'h9A);
    rd(2'd2, r); chk_eq("R11 rx1", r, 32'hBC);
    rd(2'd0, r); chk_eq("R11 cmd kept", r & 32'h0067FFFF, 32'h00030002);

    // R12 bad word length
    slave_reset();
    wr(2'd1, cfgw(0, 0, 0, 3, 32'h0800_0000));
    wr(2'd0, cmdw(1, 1, 1, 0, 0, 0));
    rd(2'd3, r); chk_eq("R12 not busy", {31'h0, r[0]}, 32'h0);
    rd(2'd1, r); chk_eq("R12 flag", {31'h0, r[26]}, 32'h1);
    chk_eq("R12 no edges", 32'(edge_cnt), 32'd0);
    wr(2'd1, cfgw(0, 0, 0, 4, 32'h0400_0000));
    rd(2'd1, r); chk_eq("R13 restore", r, 32'h00004000);

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule